// File: doc/BRIEF.md
# Power Control Register with Over-drive Handshake

This block holds the 32-bit control word of a microcontroller power controller. Software reads and writes it over a minimal bus made of an address, a write enable, write data and combinational read data. Most fields are plain storage whose values drive output ports directly. These include voltage scaling, the under-drive select, the deep-sleep selects, the voltage-detector enable and threshold, and backup-domain write access.

Two bits are special. They enable over-drive and switch over-drive. Hardware guards and clears both of them. A write to either bit only lands while an on-chip or external high-speed oscillator clocks the system. The switch bit can only be raised while the regulator reports over-drive ready. Both bits fall on a Stop-mode exit pulse, and the switch bit also falls whenever the enable bit is zero. Every change of the switch bit raises a system-clock stall output. The stall stays high until the regulator signals that the switch is complete, or for a fixed number of cycles when that signal is not used. Two write-one bits produce one-cycle pulses that clear the standby and wakeup status flags kept elsewhere.

Top module: `pwrctl_reg`

## Requirements
- R1: After synchronous reset the register reads 0x0000C000: voltage scaling is 11 and every other field is 0.
- R2: Bits 31:20 and bit 12 always read 0 and ignore writes. A read at any address other than REG_OFFSET returns 0, and a write there changes nothing.
- R3: The plain fields are read/write and drive their output ports. These are under-drive 19:18, voltage scaling 15:14, ADC supply option 13, main-regulator under-drive 11, low-power-regulator under-drive 10, flash power-down 9, backup write access 8, detector level 7:5, detector enable 4, deep-sleep standby select 1 and low-power deep-sleep 0.
- R4: Writes to the over-drive enable bit (16) and the switch bit (17) are ignored unless `sysclk_sel_i` is 00 (internal high-speed oscillator) or 01 (external high-speed oscillator).
- R5: Writing 1 to bit 17 while `od_ready_i` is low leaves the switch bit unchanged.
- R6: The switch bit is forced to 0 whenever the enable bit becomes or stays 0, including a write that clears bit 16 while setting bit 17.
- R7: A `stop_exit_i` pulse clears bits 16 and 17 on the next edge. It takes priority over a write in the same cycle.
- R8: Writing 1 to bit 3 or bit 2 gives a one-cycle pulse on `clr_sby_flag_o` or `clr_wake_flag_o` in the cycle after the write. Both bits always read 0.
- R9: Any change of the switch bit raises `clk_stall_o` in the same cycle the new value appears. With USE_SW_READY=1 the stall falls on the edge after `od_sw_ready_i` is seen high. Otherwise it lasts STALL_CYCLES cycles.
- R10: A `standby_wake_i` pulse reloads 0x0000C000 without raising the stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_i | input | ADDR_W | Bus address |
| wr_en_i | input | 1 | Bus write strobe |
| wdata_i | input | 32 | Bus write data |
| rdata_o | output | 32 | Bus read data (combinational) |
| sysclk_sel_i | input | 2 | Current system clock source: 00 internal osc, 01 external osc, 1x PLL |
| od_ready_i | input | 1 | Over-drive ready from the regulator |
| od_sw_ready_i | input | 1 | Over-drive switch complete from the regulator |
| stop_exit_i | input | 1 | One-cycle Stop-mode exit pulse |
| standby_wake_i | input | 1 | One-cycle Standby wakeup pulse |
| vscale_o | output | 2 | Voltage scaling |
| udrive_o | output | 2 | Under-drive select |
| adc_dc_o | output | 1 | ADC supply option |
| mr_ud_o | output | 1 | Main regulator under-drive in deep sleep |
| lp_ud_o | output | 1 | Low-power regulator under-drive in deep sleep |
| flash_pd_o | output | 1 | Flash power-down in deep sleep |
| bkp_wr_o | output | 1 | Backup-domain write access |
| pvd_lvl_o | output | 3 | Voltage-detector threshold |
| pvd_en_o | output | 1 | Voltage-detector enable |
| pdds_o | output | 1 | Deep sleep enters standby |
| lpds_o | output | 1 | Low-power regulator in deep sleep |
| od_en_o | output | 1 | Over-drive enable |
| od_sw_o | output | 1 | Over-drive switch |
| clk_stall_o | output | 1 | System clock stall during an over-drive switch |
| clr_sby_flag_o | output | 1 | Pulse clearing the standby flag |
| clr_wake_flag_o | output | 1 | Pulse clearing the wakeup flag |

## Verification
The hardest case to reach is a Stop exit that lands in the same cycle as a software write setting both over-drive bits. Getting there needs a legal clock source, a high ready flag and an already enabled over-drive. The stimulus first builds that state through ordinary writes and waits out the stall. It then raises the Stop pulse and the write strobe on the same falling edge. A second hard case is a write that clears the enable while setting the switch bit. It is driven from the fully enabled state, so the stall must appear even though the switch bit only falls.

// File: rtl/pwrctl_pkg.sv
package pwrctl_pkg;

    localparam int unsigned WORD_W = 32;
    localparam logic [WORD_W-1:0] RESET_WORD = 32'h0000_C000;

    // bit positions inside the control word
    localparam int unsigned POS_UD    = 18;
    localparam int unsigned POS_ODSW  = 17;
    localparam int unsigned POS_ODEN  = 16;
    localparam int unsigned POS_VS    = 14;
    localparam int unsigned POS_ADC   = 13;
    localparam int unsigned POS_MRUD  = 11;
    localparam int unsigned POS_LPUD  = 10;
    localparam int unsigned POS_FPD   = 9;
    localparam int unsigned POS_BKP   = 8;
    localparam int unsigned POS_LVL   = 5;
    localparam int unsigned POS_PVDE  = 4;
    localparam int unsigned POS_CSBY  = 3;
    localparam int unsigned POS_CWK   = 2;
    localparam int unsigned POS_PDDS  = 1;
    localparam int unsigned POS_LPDS  = 0;

    typedef enum logic [1:0] {
        SRC_INT_OSC = 2'b00,
        SRC_EXT_OSC = 2'b01,
        SRC_PLL_A   = 2'b10,
        SRC_PLL_B   = 2'b11
    } clk_src_e;

    typedef struct packed {
        logic [1:0] udrive;
        logic [1:0] vscale;
        logic       adc_dc;
        logic       mr_ud;
        logic       lp_ud;
        logic       flash_pd;
        logic       bkp_wr;
        logic [2:0] pvd_lvl;
        logic       pvd_en;
        logic       pdds;
        logic       lpds;
    } plain_fields_t;

    function automatic logic src_allows_od(input logic [1:0] sel);
        return (sel == SRC_INT_OSC) || (sel == SRC_EXT_OSC);
    endfunction

    function automatic plain_fields_t unpack_fields(input logic [WORD_W-1:0] w);
        plain_fields_t f;
        f.udrive   = w[POS_UD+:2];
        f.vscale   = w[POS_VS+:2];
        f.adc_dc   = w[POS_ADC];
        f.mr_ud    = w[POS_MRUD];
        f.lp_ud    = w[POS_LPUD];
        f.flash_pd = w[POS_FPD];
        f.bkp_wr   = w[POS_BKP];
        f.pvd_lvl  = w[POS_LVL+:3];
        f.pvd_en   = w[POS_PVDE];
        f.pdds     = w[POS_PDDS];
        f.lpds     = w[POS_LPDS];
        return f;
    endfunction

    function automatic logic [WORD_W-1:0] pack_word(input plain_fields_t f,
                                                    input logic od_en,
                                                    input logic od_sw);
        logic [WORD_W-1:0] w;
        w = '0;
        w[POS_UD+:2]  = f.udrive;
        w[POS_ODSW]   = od_sw;
        w[POS_ODEN]   = od_en;
        w[POS_VS+:2]  = f.vscale;
        w[POS_ADC]    = f.adc_dc;
        w[POS_MRUD]   = f.mr_ud;
        w[POS_LPUD]   = f.lp_ud;
        w[POS_FPD]    = f.flash_pd;
        w[POS_BKP]    = f.bkp_wr;
        w[POS_LVL+:3] = f.pvd_lvl;
        w[POS_PVDE]   = f.pvd_en;
        w[POS_PDDS]   = f.pdds;
        w[POS_LPDS]   = f.lpds;
        return w;
    endfunction

endpackage

// File: rtl/pwrctl_fields.sv
module pwrctl_fields
    import pwrctl_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 reload_i,
    input  logic                 wr_i,
    input  logic [WORD_W-1:0]    wdata_i,
    output plain_fields_t        fields_o,
    output logic                 clr_sby_o,
    output logic                 clr_wk_o
);

    localparam plain_fields_t FIELDS_INIT = unpack_fields(RESET_WORD);

    plain_fields_t fld_q;
    logic          sby_q, wk_q;

    // bits held elsewhere or reserved
    logic unused_wbits;
    assign unused_wbits = ^{wdata_i[WORD_W-1:20], wdata_i[POS_ODSW],
                            wdata_i[POS_ODEN], wdata_i[12]};

    always_ff @(posedge clk) begin
        if (rst || reload_i) begin
            fld_q <= FIELDS_INIT;
        end else if (wr_i) begin
            fld_q <= unpack_fields(wdata_i);
        end
    end

    always_ff @(posedge clk) begin
        if (rst || reload_i) begin
            sby_q <= 1'b0;
            wk_q  <= 1'b0;
        end else begin
            sby_q <= wr_i && wdata_i[POS_CSBY];
            wk_q  <= wr_i && wdata_i[POS_CWK];
        end
    end

    assign fields_o  = fld_q;
    assign clr_sby_o = sby_q;
    assign clr_wk_o  = wk_q;

    // R8: with no write in a cycle, no clear pulse follows
    p_pulse_needs_write_r8: assert property (@(posedge clk) disable iff (rst)
        !wr_i |=> (!clr_sby_o && !clr_wk_o));

endmodule

// File: rtl/pwrctl_od_seq.sv
module pwrctl_od_seq
    import pwrctl_pkg::*;
#(
    parameter bit          USE_SW_READY = 1'b1,
    parameter int unsigned STALL_CYCLES = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       reload_i,
    input  logic       stop_exit_i,
    input  logic       wr_i,
    input  logic       wr_en_bit_i,
    input  logic       wr_sw_bit_i,
    input  logic [1:0] sysclk_sel_i,
    input  logic       od_ready_i,
    input  logic       sw_ready_i,
    output logic       od_en_o,
    output logic       od_sw_o,
    output logic       stall_o
);

    localparam int unsigned CNT_W = (STALL_CYCLES > 1) ? $clog2(STALL_CYCLES) : 1;

    logic src_ok;
    logic en_q, sw_q, en_d, sw_d;
    logic sw_change;
    logic stall_q;

    assign src_ok = src_allows_od(sysclk_sel_i);

    always_comb begin
        en_d = en_q;
        sw_d = sw_q;
        if (stop_exit_i) begin
            en_d = 1'b0;
            sw_d = 1'b0;
        end else if (wr_i && src_ok) begin
            en_d = wr_en_bit_i;
            if (!wr_sw_bit_i)
                sw_d = 1'b0;
            else if (od_ready_i)
                sw_d = 1'b1;
        end
        if (!en_d)
            sw_d = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst || reload_i) begin
            en_q <= 1'b0;
            sw_q <= 1'b0;
        end else begin
            en_q <= en_d;
            sw_q <= sw_d;
        end
    end

    assign sw_change = (sw_d != sw_q) && !reload_i;

    generate
        if (USE_SW_READY) begin : g_rdy
            always_ff @(posedge clk) begin
                if (rst || reload_i)
                    stall_q <= 1'b0;
                else if (sw_change)
                    stall_q <= 1'b1;
                else if (sw_ready_i)
                    stall_q <= 1'b0;
            end
        end else begin : g_cnt
            logic [CNT_W-1:0] cnt_q;
            logic unused_rdy;
            assign unused_rdy = sw_ready_i;
            always_ff @(posedge clk) begin
                if (rst || reload_i) begin
                    stall_q <= 1'b0;
                    cnt_q   <= '0;
                end else if (sw_change) begin
                    stall_q <= 1'b1;
                    cnt_q   <= CNT_W'(STALL_CYCLES - 1);
                end else if (stall_q) begin
                    if (cnt_q == '0)
                        stall_q <= 1'b0;
                    else
                        cnt_q <= cnt_q - 1'b1;
                end
            end
        end
    endgenerate

    assign od_en_o = en_q;
    assign od_sw_o = sw_q;
    assign stall_o = stall_q;

    // R6: switch never set while enable is clear
    p_sw_needs_en_r6: assert property (@(posedge clk) disable iff (rst)
        od_sw_o |-> od_en_o);
    // R7: stop exit clears both bits
    p_stop_clears_r7: assert property (@(posedge clk) disable iff (rst)
        stop_exit_i |=> (!od_en_o && !od_sw_o));
    // R4: enable untouched when the clock source forbids it
    p_src_gate_r4: assert property (@(posedge clk) disable iff (rst)
        (!src_ok && !stop_exit_i && !reload_i) |=> $stable(od_en_o));
    // R5: switch cannot rise while ready is low
    p_sw_ready_r5: assert property (@(posedge clk) disable iff (rst)
        (!od_sw_o && !od_ready_i) |=> !od_sw_o);
    // R9: a rising switch bit is accompanied by stall
    p_stall_on_rise_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(od_sw_o) |-> stall_o);

endmodule

// File: rtl/pwrctl_reg.sv
module pwrctl_reg
    import pwrctl_pkg::*;
#(
    parameter int unsigned ADDR_W       = 4,
    parameter int unsigned REG_OFFSET   = 0,
    parameter bit          USE_SW_READY = 1'b1,
    parameter int unsigned STALL_CYCLES = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_en_i,
    input  logic [31:0]       wdata_i,
    output logic [31:0]       rdata_o,
    input  logic [1:0]        sysclk_sel_i,
    input  logic              od_ready_i,
    input  logic              od_sw_ready_i,
    input  logic              stop_exit_i,
    input  logic              standby_wake_i,
    output logic [1:0]        vscale_o,
    output logic [1:0]        udrive_o,
    output logic              adc_dc_o,
    output logic              mr_ud_o,
    output logic              lp_ud_o,
    output logic              flash_pd_o,
    output logic              bkp_wr_o,
    output logic [2:0]        pvd_lvl_o,
    output logic              pvd_en_o,
    output logic              pdds_o,
    output logic              lpds_o,
    output logic              od_en_o,
    output logic              od_sw_o,
    output logic              clk_stall_o,
    output logic              clr_sby_flag_o,
    output logic              clr_wake_flag_o
);

    localparam logic [ADDR_W-1:0] SEL_ADDR = ADDR_W'(REG_OFFSET);

    logic          sel, wr;
    plain_fields_t fld;

    assign sel = (addr_i == SEL_ADDR);
    assign wr  = wr_en_i && sel;

    pwrctl_fields u_fields (
        .clk       (clk),
        .rst       (rst),
        .reload_i  (standby_wake_i),
        .wr_i      (wr),
        .wdata_i   (wdata_i),
        .fields_o  (fld),
        .clr_sby_o (clr_sby_flag_o),
        .clr_wk_o  (clr_wake_flag_o)
    );

    pwrctl_od_seq #(
        .USE_SW_READY (USE_SW_READY),
        .STALL_CYCLES (STALL_CYCLES)
    ) u_od (
        .clk          (clk),
        .rst          (rst),
        .reload_i     (standby_wake_i),
        .stop_exit_i  (stop_exit_i),
        .wr_i         (wr),
        .wr_en_bit_i  (wdata_i[POS_ODEN]),
        .wr_sw_bit_i  (wdata_i[POS_ODSW]),
        .sysclk_sel_i (sysclk_sel_i),
        .od_ready_i   (od_ready_i),
        .sw_ready_i   (od_sw_ready_i),
        .od_en_o      (od_en_o),
        .od_sw_o      (od_sw_o),
        .stall_o      (clk_stall_o)
    );

    assign rdata_o = sel ? pack_word(fld, od_en_o, od_sw_o) : '0;

    assign vscale_o   = fld.vscale;
    assign udrive_o   = fld.udrive;
    assign adc_dc_o   = fld.adc_dc;
    assign mr_ud_o    = fld.mr_ud;
    assign lp_ud_o    = fld.lp_ud;
    assign flash_pd_o = fld.flash_pd;
    assign bkp_wr_o   = fld.bkp_wr;
    assign pvd_lvl_o  = fld.pvd_lvl;
    assign pvd_en_o   = fld.pvd_en;
    assign pdds_o     = fld.pdds;
    assign lpds_o     = fld.lpds;

    // R2: reserved positions and write-one bits read zero
    p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (rst)
        (rdata_o[31:20] == '0) && !rdata_o[12] && (rdata_o[3:2] == 2'b00));
    // R10: standby wakeup reloads the reset pattern
    p_wake_reload_r10: assert property (@(posedge clk) disable iff (rst)
        standby_wake_i |=> (vscale_o == 2'b11 && !od_en_o && !pvd_en_o && !clk_stall_o));

endmodule

// File: tb/pwrctl_reg_tb_top.sv
module pwrctl_reg_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  addr_i = '0;
    logic        wr_en_i = 1'b0;
    logic [31:0] wdata_i = '0;
    logic [31:0] rdata_o;
    logic [1:0]  sysclk_sel_i = 2'b00;
    logic        od_ready_i = 1'b0;
    logic        od_sw_ready_i = 1'b0;
    logic        stop_exit_i = 1'b0;
    logic        standby_wake_i = 1'b0;
    logic [1:0]  vscale_o, udrive_o;
    logic        adc_dc_o, mr_ud_o, lp_ud_o, flash_pd_o, bkp_wr_o;
    logic [2:0]  pvd_lvl_o;
    logic        pvd_en_o, pdds_o, lpds_o, od_en_o, od_sw_o, clk_stall_o;
    logic        clr_sby_flag_o, clr_wake_flag_o;

    int nchk = 0;
    int nfail = 0;

    logic        rd_req = 1'b0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #5 clk = ~clk;

    pwrctl_reg dut_i (
        .clk(clk), .rst(rst), .addr_i(addr_i), .wr_en_i(wr_en_i), .wdata_i(wdata_i),
        .rdata_o(rdata_o), .sysclk_sel_i(sysclk_sel_i), .od_ready_i(od_ready_i),
        .od_sw_ready_i(od_sw_ready_i), .stop_exit_i(stop_exit_i),
        .standby_wake_i(standby_wake_i), .vscale_o(vscale_o), .udrive_o(udrive_o),
        .adc_dc_o(adc_dc_o), .mr_ud_o(mr_ud_o), .lp_ud_o(lp_ud_o),
        .flash_pd_o(flash_pd_o), .bkp_wr_o(bkp_wr_o), .pvd_lvl_o(pvd_lvl_o),
        .pvd_en_o(pvd_en_o), .pdds_o(pdds_o), .lpds_o(lpds_o), .od_en_o(od_en_o),
        .od_sw_o(od_sw_o), .clk_stall_o(clk_stall_o),
        .clr_sby_flag_o(clr_sby_flag_o), .clr_wake_flag_o(clr_wake_flag_o)
    );

    // scoreboard monitor: compares queued read expectations
    always @(negedge clk) begin
        if (rd_req && exp_q.size() > 0) begin
            logic [31:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            nchk++;
            if (rdata_o !== e) begin
                nfail++;
                $display("FAIL %s read got %h expected %h", t, rdata_o, e);
            end
        end
    end

    task automatic chk(input string t, input logic [31:0] got, input logic [31:0] ex);
        nchk++;
        if (got !== ex) begin
            nfail++;
            $display("FAIL %s got %h expected %h", t, got, ex);
        end
    endtask

    task automatic bus_wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        addr_i  <= a;
        wr_en_i <= 1'b1;
        wdata_i <= d;
        @(negedge clk);
        wr_en_i <= 1'b0;
    endtask

    task automatic bus_rd(input logic [3:0] a, input logic [31:0] e, input string t);
        @(negedge clk);
        addr_i <= a;
        rd_req <= 1'b1;
        exp_q.push_back(e);
        tag_q.push_back(t);
        @(negedge clk);
        rd_req <= 1'b0;
        addr_i <= '0;
    endtask

    initial begin
        #2_000_000;
        nfail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst <= 1'b0;
        // R1 reset value
        bus_rd(4'd0, 32'h0000_C000, "R1");
        chk("R1 vscale", {30'd0, vscale_o}, 32'd3);
        chk("R1 stall", {31'd0, clk_stall_o}, 32'd0);

        // R4 writes to over-drive ignored with PLL as clock, R8 pulses
        sysclk_sel_i <= 2'b10;
        od_ready_i   <= 1'b1;
        bus_wr(4'd0, 32'hFFFF_FFFF);
        chk("R8 sby pulse", {31'd0, clr_sby_flag_o}, 32'd1);
        chk("R8 wake pulse", {31'd0, clr_wake_flag_o}, 32'd1);
        chk("R4 od_en", {31'd0, od_en_o}, 32'd0);
        @(negedge clk);
        chk("R8 pulse width", {30'd0, clr_sby_flag_o, clr_wake_flag_o}, 32'd0);
        // R2 reserved bits zero, R8 write-one bits read zero
        bus_rd(4'd0, 32'h000C_EFF3, "R2/R8 all-ones");

        // R3 plain storage pattern
        bus_wr(4'd0, 32'h0);
        bus_rd(4'd0, 32'h0, "R3 zero");
        bus_wr(4'd0, 32'h0000_4A51);
        chk("R3 vscale", {30'd0, vscale_o}, 32'd1);
        chk("R3 pvd_lvl", {29'd0, pvd_lvl_o}, 32'd2);
        chk("R3 bits", {26'd0, mr_ud_o, flash_pd_o, pvd_en_o, lpds_o, lp_ud_o, bkp_wr_o},
            32'b111100);

        // R5 switch refused without ready
        sysclk_sel_i <= 2'b00;
        od_ready_i   <= 1'b0;
        bus_wr(4'd0, 32'h0003_4A51);
        chk("R5 od_en", {31'd0, od_en_o}, 32'd1);
        chk("R5 od_sw", {31'd0, od_sw_o}, 32'd0);
        chk("R5 no stall", {31'd0, clk_stall_o}, 32'd0);
        bus_rd(4'd0, 32'h0001_4A51, "R5 read");

        // R9 switch with ready, stall held until switch-ready
        od_ready_i <= 1'b1;
        bus_wr(4'd0, 32'h0003_4A51);
        chk("R9 od_sw", {31'd0, od_sw_o}, 32'd1);
        chk("R9 stall up", {31'd0, clk_stall_o}, 32'd1);
        repeat (4) @(negedge clk);
        chk("R9 stall held", {31'd0, clk_stall_o}, 32'd1);
        od_sw_ready_i <= 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R9 stall down", {31'd0, clk_stall_o}, 32'd0);
        bus_rd(4'd0, 32'h0003_4A51, "R9 read");

        // R4 clearing ignored under PLL
        sysclk_sel_i <= 2'b11;
        bus_wr(4'd0, 32'h0000_4A51);
        chk("R4 hold en", {30'd0, od_en_o, od_sw_o}, 32'd3);

        // R6 clearing enable drops switch even if bit 17 written 1
        sysclk_sel_i <= 2'b01;
        bus_wr(4'd0, 32'h0002_4A51);
        chk("R6 bits", {30'd0, od_en_o, od_sw_o}, 32'd0);
        chk("R9 stall on fall", {31'd0, clk_stall_o}, 32'd1);
        @(negedge clk);
        chk("R9 stall released", {31'd0, clk_stall_o}, 32'd0);

        // R7 stop exit beats a same-cycle write
        sysclk_sel_i <= 2'b00;
        bus_wr(4'd0, 32'h0003_4A51);
        repeat (2) @(negedge clk);
        chk("R7 pre", {30'd0, od_en_o, od_sw_o}, 32'd3);
        stop_exit_i <= 1'b1;
        wr_en_i     <= 1'b1;
        wdata_i     <= 32'h0003_4A51;
        @(negedge clk);
        stop_exit_i <= 1'b0;
        wr_en_i     <= 1'b0;
        chk("R7 cleared", {30'd0, od_en_o, od_sw_o}, 32'd0);
        repeat (2) @(negedge clk);
        bus_rd(4'd0, 32'h0000_4A51, "R7 read");

        // R2 other address: read zero, write ignored
        bus_rd(4'd5, 32'h0, "R2 other addr");
        bus_wr(4'd5, 32'h0000_0000);
        bus_rd(4'd0, 32'h0000_4A51, "R2 write elsewhere");

        // R10 standby wake reload
        @(negedge clk);
        standby_wake_i <= 1'b1;
        @(negedge clk);
        standby_wake_i <= 1'b0;
        chk("R10 pvd_en", {31'd0, pvd_en_o}, 32'd0);
        chk("R10 stall", {31'd0, clk_stall_o}, 32'd0);
        bus_rd(4'd0, 32'h0000_C000, "R10 read");

        repeat (2) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

endmodule